// File: doc/BRIEF.md
# Configurable Serial Frame Shifter

This block pairs a frame transmitter with a frame receiver for asynchronous-style character frames whose shape is chosen at run time. The frame shape has three settings: a data length of five to nine bits, a parity mode of none, even or odd, and one or two stop bits. That makes thirty frame formats, and the block accepts every one of them. The transmitter takes a data word when it is free. It then puts the frame on its serial line one bit per change strobe. The receiver watches its serial line on each sample strobe. It finds the start bit, gathers the data bits and reports the word together with a parity flag and a framing flag.

The strobes come from outside, so the block has no bit-rate logic of its own. The surrounding logic decides where in the bit period the line changes and where it is sampled. Each side captures the frame settings once per frame: the transmitter when it accepts a word, and the receiver when it sees a start bit. This lets software rewrite the settings while a frame is in flight without harming that frame.

Top module: `frame_shifter`

## Requirements
- R1: After reset, `tx_line` is 1 and `tx_ready` is 1, and `rx_valid` is 0. With no word loaded, `tx_line` stays at 1 whatever `tx_chg` does.
- R2: A word on `tx_data` is taken only when `tx_load` is high while `tx_ready` is 1, and `tx_ready` is 0 from the next cycle on. A `tx_load` pulse while `tx_ready` is 0 has no effect. A `tx_chg` that falls in the same cycle as the accepted load does not move the line. The start bit appears on the first `tx_chg` after the load cycle.
- R3: The line changes only in the cycle after a `tx_chg` pulse, and each pulse moves it by one bit. The bits come in this order: a start bit of 0, the data bits with bit 0 first, the parity bit if enabled, then the stop bits at 1.
- R4: `cfg_len` sets the data length: codes 0, 1, 2, 3 and 4 give 5, 6, 7, 8 and 9 bits. Codes 5, 6 and 7 also give 9 bits.
- R5: `cfg_par` sets the parity mode. Codes 00 and 01 send no parity bit. Code 10 sends even parity, which is the XOR of the active data bits. Code 11 sends odd parity, which is the inverse of that XOR.
- R6: `cfg_stop2` = 1 gives two stop bits and 0 gives one. `tx_ready` returns to 1 in the cycle after the `tx_chg` that follows the last stop bit. At that point the line stays at 1.
- R7: The transmitter captures the frame settings in the load cycle. The receiver captures them at the start-bit sample. Later changes to `cfg_len`, `cfg_par` or `cfg_stop2` do not alter a frame already in progress.
- R8: While the receiver is idle, an `rx_smp` that sees `rx_line` at 0 begins a frame. Samples that see 1 are ignored.
- R9: `rx_valid` is a one-cycle pulse in the cycle after the sample of the first stop bit. The received bits then sit on `rx_data` with bit 0 first, and any bits above the data length are 0. The receiver checks only the first stop bit, then returns to idle.
- R10: `rx_par_err` is 1 with `rx_valid` when parity is enabled and the received parity bit differs from the value R5 gives for the received data. It is always 0 when parity is off.
- R11: `rx_frm_err` is 1 with `rx_valid` exactly when the first stop bit was sampled at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_len | input | 3 | Data length code (R4) |
| cfg_par | input | 2 | Parity mode code (R5) |
| cfg_stop2 | input | 1 | 1 selects two stop bits |
| tx_load | input | 1 | Load request for `tx_data` |
| tx_data | input | 9 | Word to send, bit 0 sent first |
| tx_chg | input | 1 | Transmit change strobe, one cycle |
| tx_ready | output | 1 | Transmitter free to accept a word |
| tx_line | output | 1 | Serial output, rests at 1 |
| rx_smp | input | 1 | Receive sample strobe, one cycle |
| rx_line | input | 1 | Serial input |
| rx_valid | output | 1 | One-cycle pulse when a frame is complete |
| rx_data | output | 9 | Received word, unused upper bits 0 |
| rx_par_err | output | 1 | Parity mismatch for the frame just reported |
| rx_frm_err | output | 1 | First stop bit sampled at 0 |

## Verification
The two transmit functions that can meet in one cycle are the acceptance of a word and the change strobe. A strobe in the load cycle could be taken as the start bit and shift the whole frame one bit early. The bench raises `tx_load` and `tx_chg` together. It checks that the line is still 1 after that edge and that the start bit appears only on the next strobe. A second collision is a settings change or a stray load in the middle of a frame. The bench judges it by comparing every line bit and the received word against a frame built from the settings that were in force when the word was loaded.

// File: rtl/frame_pkg.sv
package frame_pkg;

    localparam int DATA_MAX = 9;
    localparam int DATA_MIN = 5;
    localparam int CNT_W    = $clog2(DATA_MAX + 1);
    localparam int LEN_CODE_W = 3;
    localparam int PAR_CODE_W = 2;

    typedef logic [DATA_MAX-1:0] word_t;
    typedef logic [CNT_W-1:0]    cnt_t;

    typedef struct packed {
        cnt_t len;
        logic par_en;
        logic par_odd;
        logic stop2;
    } fmt_t;

    typedef enum logic [2:0] {
        TX_IDLE, TX_ARMED, TX_START, TX_DATA, TX_PAR, TX_STOP1, TX_STOP2
    } tx_state_e;

    typedef enum logic [1:0] {
        RX_IDLE, RX_DATA, RX_PAR, RX_STOP
    } rx_state_e;

    function automatic word_t len_mask(input cnt_t len);
        word_t m;
        for (int i = 0; i < DATA_MAX; i++) begin
            m[i] = (cnt_t'(i) < len);
        end
        return m;
    endfunction

    function automatic logic parity_of(input word_t d, input cnt_t len, input logic odd);
        return (^(d & len_mask(len))) ^ odd;
    endfunction

endpackage

// File: rtl/frame_cfg_decode.sv
module frame_cfg_decode
    import frame_pkg::*;
(
    input  logic [LEN_CODE_W-1:0] len_code,
    input  logic [PAR_CODE_W-1:0] par_code,
    input  logic                  stop2,
    output fmt_t                  fmt
);
    localparam logic [LEN_CODE_W-1:0] TOP_CODE = LEN_CODE_W'(DATA_MAX - DATA_MIN);

    always_comb begin
        if (len_code >= TOP_CODE) begin
            fmt.len = cnt_t'(DATA_MAX);
        end else begin
            fmt.len = cnt_t'(DATA_MIN) + cnt_t'(len_code);
        end
        fmt.par_en  = par_code[1];
        fmt.par_odd = par_code[0];
        fmt.stop2   = stop2;
    end
endmodule

// File: rtl/frame_tx.sv
module frame_tx
    import frame_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  fmt_t  fmt_in,
    input  logic  load,
    input  word_t data,
    input  logic  chg,
    output logic  ready,
    output logic  line
);
    tx_state_e st;
    fmt_t      fmt_q;
    word_t     sh;
    cnt_t      sent;
    logic      par_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= TX_IDLE;
            line  <= 1'b1;
            fmt_q <= '0;
            sh    <= '0;
            sent  <= '0;
            par_q <= 1'b0;
        end else begin
            case (st)
                TX_IDLE: begin
                    if (load) begin
                        fmt_q <= fmt_in;
                        sh    <= data & len_mask(fmt_in.len);
                        par_q <= parity_of(data, fmt_in.len, fmt_in.par_odd);
                        st    <= TX_ARMED;
                    end
                end
                TX_ARMED: begin
                    if (chg) begin
                        line <= 1'b0;
                        st   <= TX_START;
                    end
                end
                TX_START: begin
                    if (chg) begin
                        line <= sh[0];
                        sh   <= sh >> 1;
                        sent <= cnt_t'(1);
                        st   <= TX_DATA;
                    end
                end
                TX_DATA: begin
                    if (chg) begin
                        if (sent == fmt_q.len) begin
                            if (fmt_q.par_en) begin
                                line <= par_q;
                                st   <= TX_PAR;
                            end else begin
                                line <= 1'b1;
                                st   <= TX_STOP1;
                            end
                        end else begin
                            line <= sh[0];
                            sh   <= sh >> 1;
                            sent <= sent + cnt_t'(1);
                        end
                    end
                end
                TX_PAR: begin
                    if (chg) begin
                        line <= 1'b1;
                        st   <= TX_STOP1;
                    end
                end
                TX_STOP1: begin
                    if (chg) begin
                        st <= fmt_q.stop2 ? TX_STOP2 : TX_IDLE;
                    end
                end
                TX_STOP2: begin
                    if (chg) begin
                        st <= TX_IDLE;
                    end
                end
                default: st <= TX_IDLE;
            endcase
        end
    end

    assign ready = (st == TX_IDLE);

    // R1
    idle_line_high_chk: assert property (@(posedge clk) disable iff (rst)
        ready |-> line);
    // R3
    line_moves_on_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(line) |-> $past(chg));
    // R6
    ready_rise_on_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ready) |-> $past(chg));
    // R2
    load_drops_ready_chk: assert property (@(posedge clk) disable iff (rst)
        (ready && load) |=> !ready);
endmodule

// File: rtl/frame_rx.sv
module frame_rx
    import frame_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  fmt_t  fmt_in,
    input  logic  smp,
    input  logic  line,
    output logic  valid,
    output word_t data,
    output logic  par_err,
    output logic  frm_err
);
    rx_state_e st;
    fmt_t      fmt_q;
    word_t     acc;
    cnt_t      got;
    logic      par_bit_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= RX_IDLE;
            fmt_q     <= '0;
            acc       <= '0;
            got       <= '0;
            par_bit_q <= 1'b0;
            valid     <= 1'b0;
            data      <= '0;
            par_err   <= 1'b0;
            frm_err   <= 1'b0;
        end else begin
            valid <= 1'b0;
            case (st)
                RX_IDLE: begin
                    if (smp && !line) begin
                        fmt_q <= fmt_in;
                        acc   <= '0;
                        got   <= '0;
                        st    <= RX_DATA;
                    end
                end
                RX_DATA: begin
                    if (smp) begin
                        acc[got] <= line;
                        got      <= got + cnt_t'(1);
                        if (got == fmt_q.len - cnt_t'(1)) begin
                            st <= fmt_q.par_en ? RX_PAR : RX_STOP;
                        end
                    end
                end
                RX_PAR: begin
                    if (smp) begin
                        par_bit_q <= line;
                        st        <= RX_STOP;
                    end
                end
                RX_STOP: begin
                    if (smp) begin
                        valid   <= 1'b1;
                        data    <= acc;
                        frm_err <= !line;
                        par_err <= fmt_q.par_en &&
                                   (par_bit_q != parity_of(acc, fmt_q.len, fmt_q.par_odd));
                        st      <= RX_IDLE;
                    end
                end
                default: st <= RX_IDLE;
            endcase
        end
    end

    // R9
    valid_single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        valid |=> !valid);
    // R9
    valid_follows_sample_chk: assert property (@(posedge clk) disable iff (rst)
        valid |-> $past(smp));
    // R10
    no_parity_no_error_chk: assert property (@(posedge clk) disable iff (rst)
        (valid && !fmt_q.par_en) |-> !par_err);
endmodule

// File: rtl/frame_shifter.sv
module frame_shifter
    import frame_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic [LEN_CODE_W-1:0] cfg_len,
    input  logic [PAR_CODE_W-1:0] cfg_par,
    input  logic                  cfg_stop2,
    input  logic                  tx_load,
    input  logic [DATA_MAX-1:0]   tx_data,
    input  logic                  tx_chg,
    output logic                  tx_ready,
    output logic                  tx_line,
    input  logic                  rx_smp,
    input  logic                  rx_line,
    output logic                  rx_valid,
    output logic [DATA_MAX-1:0]   rx_data,
    output logic                  rx_par_err,
    output logic                  rx_frm_err
);
    fmt_t fmt_now;

    frame_cfg_decode u_dec (
        .len_code (cfg_len),
        .par_code (cfg_par),
        .stop2    (cfg_stop2),
        .fmt      (fmt_now)
    );

    frame_tx u_tx (
        .clk    (clk),
        .rst    (rst),
        .fmt_in (fmt_now),
        .load   (tx_load),
        .data   (tx_data),
        .chg    (tx_chg),
        .ready  (tx_ready),
        .line   (tx_line)
    );

    frame_rx u_rx (
        .clk     (clk),
        .rst     (rst),
        .fmt_in  (fmt_now),
        .smp     (rx_smp),
        .line    (rx_line),
        .valid   (rx_valid),
        .data    (rx_data),
        .par_err (rx_par_err),
        .frm_err (rx_frm_err)
    );
endmodule

// File: tb/sim_frame_shifter.sv
`timescale 1ns/1ps
module sim_frame_shifter;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] cfg_len = 3'd3;
    logic [1:0] cfg_par = 2'b00;
    logic       cfg_stop2 = 1'b0;
    logic       tx_load = 1'b0;
    logic [8:0] tx_data = '0;
    logic       tx_chg = 1'b0;
    logic       tx_ready, tx_line;
    logic       rx_smp = 1'b0;
    logic       rx_line;
    logic       rx_valid;
    logic [8:0] rx_data;
    logic       rx_par_err, rx_frm_err;
    logic       man_sel = 1'b0;
    logic       man_bit = 1'b1;

    int checks = 0;
    int fails  = 0;
    int vcount = 0;
    logic [8:0] cap_data = '0;
    logic       cap_pe = 1'b0;
    logic       cap_fe = 1'b0;
    bit         done = 1'b0;

    always #2 clk = ~clk;

    assign rx_line = man_sel ? man_bit : tx_line;

    frame_shifter u0 (
        .clk(clk), .rst(rst), .cfg_len(cfg_len), .cfg_par(cfg_par), .cfg_stop2(cfg_stop2),
        .tx_load(tx_load), .tx_data(tx_data), .tx_chg(tx_chg), .tx_ready(tx_ready),
        .tx_line(tx_line), .rx_smp(rx_smp), .rx_line(rx_line), .rx_valid(rx_valid),
        .rx_data(rx_data), .rx_par_err(rx_par_err), .rx_frm_err(rx_frm_err)
    );

    always @(posedge clk) begin
        if (rx_valid) begin
            vcount   = vcount + 1;
            cap_data = rx_data;
            cap_pe   = rx_par_err;
            cap_fe   = rx_frm_err;
        end
    end

    function automatic int len_of(input logic [2:0] c);
        return (c >= 3'd4) ? 9 : 5 + int'(c);
    endfunction

    function automatic logic [8:0] mask_of(input logic [2:0] c);
        logic [8:0] m = '0;
        for (int i = 0; i < len_of(c); i++) m[i] = 1'b1;
        return m;
    endfunction

    function automatic int frame_n(input logic [2:0] c, input logic [1:0] p, input logic s2);
        return 1 + len_of(c) + (p[1] ? 1 : 0) + (s2 ? 2 : 1);
    endfunction

    function automatic logic [15:0] frame_bits(input logic [8:0] d, input logic [2:0] c,
                                               input logic [1:0] p, input logic s2);
        logic [15:0] b = '1;
        int k = 1;
        b[0] = 1'b0;
        for (int i = 0; i < len_of(c); i++) begin
            b[k] = d[i];
            k++;
        end
        if (p[1]) begin
            b[k] = (^(d & mask_of(c))) ^ p[0];
            k++;
        end
        return b;
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic strobe_chg();
        @(negedge clk) tx_chg = 1'b1;
        @(negedge clk) tx_chg = 1'b0;
    endtask

    task automatic strobe_smp();
        @(negedge clk) rx_smp = 1'b1;
        @(negedge clk) rx_smp = 1'b0;
    endtask

    // Sends one frame in loopback and checks every line bit and the received word.
    task automatic send_frame(input logic [8:0] d, input logic [2:0] c, input logic [1:0] p,
                              input logic s2, input bit coincide, input bit disturb);
        logic [15:0] b = frame_bits(d, c, p, s2);
        int n = frame_n(c, p, s2);
        int v0;
        @(negedge clk);
        check(tx_ready == 1'b1, "R2 ready before load", int'(tx_ready), 1);
        cfg_len = c; cfg_par = p; cfg_stop2 = s2; tx_data = d;
        tx_load = 1'b1;
        tx_chg = coincide;
        @(negedge clk);
        tx_load = 1'b0;
        tx_chg = 1'b0;
        check(tx_ready == 1'b0, "R2 ready low after load", int'(tx_ready), 0);
        check(tx_line == 1'b1, "R2 line idle after load cycle", int'(tx_line), 1);
        v0 = vcount;
        for (int i = 0; i < n; i++) begin
            if (disturb && i == 2) begin
                // R7 settings change and stray load mid-frame
                cfg_len = ~c; cfg_par = ~p; cfg_stop2 = ~s2;
                tx_data = ~d; tx_load = 1'b1;
                @(negedge clk) tx_load = 1'b0;
            end
            strobe_chg();
            check(tx_line == b[i], $sformatf("R3 frame bit %0d", i), int'(tx_line), int'(b[i]));
            strobe_smp();
        end
        check(tx_ready == 1'b0, "R6 ready low during last stop", int'(tx_ready), 0);
        strobe_chg();
        check(tx_ready == 1'b1, "R6 ready after last stop", int'(tx_ready), 1);
        check(vcount == v0 + 1, "R9 one valid per frame", vcount - v0, 1);
        check(cap_data == (d & mask_of(c)), "R9 R4 received word", int'(cap_data),
              int'(d & mask_of(c)));
        check(cap_pe == 1'b0, "R10 no parity error", int'(cap_pe), 0);
        check(cap_fe == 1'b0, "R11 no framing error", int'(cap_fe), 0);
        if (disturb) begin
            // R2 stray load ignored: no second frame starts
            strobe_chg();
            strobe_smp();
            strobe_chg();
            check(tx_line == 1'b1, "R2 no frame from busy load", int'(tx_line), 1);
            check(tx_ready == 1'b1, "R2 still ready", int'(tx_ready), 1);
            check(vcount == v0 + 1, "R8 idle high samples ignored", vcount - v0, 1);
        end
    endtask

    // Drives the receiver directly with a bit pattern.
    task automatic rx_manual(input logic [15:0] b, input int n, input logic [2:0] c,
                             input logic [1:0] p, input logic [8:0] exp_d,
                             input logic exp_pe, input logic exp_fe, input string tag);
        int v0 = vcount;
        cfg_len = c; cfg_par = p;
        man_sel = 1'b1;
        for (int i = 0; i < n; i++) begin
            @(negedge clk) man_bit = b[i];
            strobe_smp();
        end
        @(negedge clk) man_bit = 1'b1;
        @(negedge clk);
        check(vcount == v0 + 1, {tag, " valid"}, vcount - v0, 1);
        check(cap_data == exp_d, {tag, " data"}, int'(cap_data), int'(exp_d));
        check(cap_pe == exp_pe, {"R10 ", tag, " parity flag"}, int'(cap_pe), int'(exp_pe));
        check(cap_fe == exp_fe, {"R11 ", tag, " framing flag"}, int'(cap_fe), int'(exp_fe));
        man_sel = 1'b0;
    endtask

    task automatic test_reset();
        @(negedge clk);
        check(tx_line == 1'b1, "R1 reset line", int'(tx_line), 1);
        check(tx_ready == 1'b1, "R1 reset ready", int'(tx_ready), 1);
        check(rx_valid == 1'b0, "R1 reset valid", int'(rx_valid), 0);
        strobe_chg();
        strobe_chg();
        check(tx_line == 1'b1, "R1 line idle under strobes", int'(tx_line), 1);
    endtask

    task automatic test_formats();
        send_frame(9'h015, 3'd0, 2'b00, 1'b0, 1'b0, 1'b0); // R4 5 bits, R5 none
        send_frame(9'h0A7, 3'd3, 2'b10, 1'b1, 1'b0, 1'b0); // R5 even, R6 two stops
        send_frame(9'h1C3, 3'd4, 2'b11, 1'b0, 1'b0, 1'b0); // R4 9 bits, R5 odd
        send_frame(9'h1FF, 3'd2, 2'b11, 1'b1, 1'b0, 1'b0); // R4 7 bits masked
        send_frame(9'h02D, 3'd1, 2'b10, 1'b0, 1'b0, 1'b0); // R4 6 bits
        send_frame(9'h155, 3'd6, 2'b01, 1'b1, 1'b0, 1'b0); // R4 code 6 as 9, R5 code 01 none
    endtask

    task automatic test_collisions();
        send_frame(9'h0B2, 3'd3, 2'b11, 1'b0, 1'b1, 1'b0); // R2 load with strobe
        send_frame(9'h12E, 3'd4, 2'b10, 1'b1, 1'b0, 1'b1); // R7 mid-frame changes
    endtask

    task automatic test_rx_errors();
        logic [15:0] b;
        // R8 idle high samples then R10 wrong even parity, 8 bits
        man_sel = 1'b1; man_bit = 1'b1;
        strobe_smp();
        strobe_smp();
        man_sel = 1'b0;
        b = frame_bits(9'h0C5, 3'd3, 2'b10, 1'b0);
        b[9] = ~b[9];
        rx_manual(b, 11, 3'd3, 2'b10, 9'h0C5, 1'b1, 1'b0, "R10 even mismatch");
        // R10 wrong odd parity, 9 bits
        b = frame_bits(9'h10F, 3'd4, 2'b11, 1'b0);
        b[10] = ~b[10];
        rx_manual(b, 12, 3'd4, 2'b11, 9'h10F, 1'b1, 1'b0, "R10 odd mismatch");
        // R11 first stop low, 5 bits no parity
        b = frame_bits(9'h00A, 3'd0, 2'b00, 1'b0);
        b[6] = 1'b0;
        rx_manual(b, 7, 3'd0, 2'b00, 9'h00A, 1'b0, 1'b1, "R11 stop low");
        // R11 R10 both flags, 6 bits even
        b = frame_bits(9'h033, 3'd1, 2'b10, 1'b0);
        b[7] = ~b[7];
        b[8] = 1'b0;
        rx_manual(b, 9, 3'd1, 2'b10, 9'h033, 1'b1, 1'b1, "R11 both flags");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        test_reset();
        test_formats();
        test_collisions();
        test_rx_errors();
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule